// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides whether a received frame should be kept, based only on its 48-bit destination address. The address enters one byte per cycle on a small byte stream with a start marker. While the bytes arrive, the block folds them into a CRC-32 hash, and it keeps the whole address in a shift register. When the sixth byte arrives, it compares the address against a table of exact-match entries and looks up one bit of a 512-bit hash bitmap. It then applies three mode bits: promiscuous, all-multicast and broadcast enable. One cycle after the sixth byte, it reports an accept flag, a match-type code and the 9-bit hash index.

A simple register write port loads the tables and the mode bits. Software loads exact entry 0 with the station's own unicast address, and entries 1 to 15 with group addresses. Group addresses that do not fit in the table go into the hash bitmap. Software clears every location at initialisation. For that reason an all-zero exact entry is treated as empty.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid_o` is low, all mode bits are clear and all table locations are zero, so a frame sent straight after reset is rejected, including the all-ones address.
- R2: A byte with `byte_sof_i` high starts a new address, even in the middle of a previous one. Idle cycles between bytes are allowed. The address bytes arrive in order, byte 0 first. `dec_valid_o` pulses for exactly one cycle, in the cycle after the sixth byte is taken. Bytes without a start marker that arrive after the sixth byte are ignored.
- R3: `hash_idx_o` equals bits [31:23] of a CRC register computed as follows. The register starts at 0xFFFFFFFF. It takes bytes 0 to 5, each byte least significant bit first. At each step the register shifts left, and when the bit shifted out XOR the data bit is 1, the register is XORed with 0x04C11DB7.
- R4: The exact table has 16 entries. Entry e, word w (w = 0, 1, 2) is written at config address 3*e+w. Word w holds address byte 4-2w in bits [15:8] and byte 5-2w in bits [7:0]. An address equal to a loaded entry is accepted with code 1.
- R5: An exact entry whose 48 bits are all zero never matches, so an all-zero destination address is rejected unless the promiscuous bit is set.
- R6: The hash bitmap is 32 words of 16 bits, and word k is written at config address 64+k. A group address is one with bit 0 of byte 0 set. A group address is accepted with code 2 when bit `hash_idx_o[3:0]` of word `hash_idx_o[8:4]` is set.
- R7: Config address 96 holds the mode bits: bit 0 is promiscuous, bit 1 is all-multicast and bit 2 is broadcast enable. The all-ones address is accepted with code 3 only when broadcast enable is set. Otherwise it is rejected, even when all-multicast is set or an exact entry or hash bit would match it.
- R8: With all-multicast set, every group address other than all-ones is accepted with code 4, unless an exact entry matches it, in which case the code is 1.
- R9: With promiscuous set, every address is accepted with code 4.
- R10: A unicast address (byte 0 bit 0 clear) is accepted only by an exact hit or by promiscuous mode; its hash bit is not consulted.
- R11: `dec_accept_o` is high exactly when `dec_kind_o` is nonzero. Outside the `dec_valid_o` cycle, `dec_accept_o`, `dec_kind_o` and `hash_idx_o` are all zero. The codes are 0 reject, 1 exact, 2 hash, 3 broadcast, 4 promiscuous or all-multicast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Config write strobe |
| cfg_addr_i | input | 7 | Config word address |
| cfg_wdata_i | input | 16 | Config write data |
| byte_valid_i | input | 1 | Address byte present |
| byte_sof_i | input | 1 | Marks byte 0 of an address |
| byte_data_i | input | 8 | Address byte |
| dec_valid_o | output | 1 | Decision pulse, one cycle after the sixth byte |
| dec_accept_o | output | 1 | Frame accepted |
| dec_kind_o | output | 3 | Match-type code |
| hash_idx_o | output | 9 | CRC-derived bitmap index |

## Verification
A wrong CRC state or a wrong byte counter shows at the ports in the very next decision. A bad CRC state gives a `hash_idx_o` that differs from the software model, and the hash lookup then picks the wrong bit. A bad counter makes the decision pulse early, late, twice or not at all. A table bit stored in the wrong place shows as a wrong code for the directed addresses that aim at that entry or bitmap word. Random addresses, drawn from the loaded table and from the whole space, cover the order in which the modes take precedence.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_BITS  = ADDR_BYTES * 8;

  typedef enum logic [2:0] {
    KIND_REJECT = 3'd0,
    KIND_EXACT  = 3'd1,
    KIND_HASH   = 3'd2,
    KIND_BCAST  = 3'd3,
    KIND_OPEN   = 3'd4
  } match_kind_e;

  // bit 0 promiscuous, bit 1 all-multicast, bit 2 broadcast enable
  typedef struct packed {
    logic bcast_en;
    logic all_multi;
    logic promisc;
  } mode_t;

  // serial CRC-32 step over one byte, lsb first
  function automatic logic [31:0] crc_byte(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0};
      if (fb) r = r ^ 32'h04C1_1DB7;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int N_EXACT    = 16,
  parameter int HASH_WORDS = 32,
  parameter int CFG_AW     = 7,
  parameter int HASH_BASE  = 64,
  parameter int MODE_ADDR  = 96
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 we_i,
  input  logic [CFG_AW-1:0]                    addr_i,
  input  logic [15:0]                          wdata_i,
  output logic [N_EXACT-1:0][ADDR_BITS-1:0]    exact_o,
  output logic [HASH_WORDS-1:0][15:0]          hash_o,
  output mode_t                                mode_o
);
  localparam int WORDS_PER_ENTRY = ADDR_BITS / 16;

  for (genvar e = 0; e < N_EXACT; e++) begin : g_entry
    for (genvar w = 0; w < WORDS_PER_ENTRY; w++) begin : g_word
      localparam logic [CFG_AW-1:0] WADDR = CFG_AW'(e * WORDS_PER_ENTRY + w);
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         exact_o[e][16*w +: 16] <= '0;
        else if (we_i && addr_i == WADDR)    exact_o[e][16*w +: 16] <= wdata_i;
      end
    end
  end

  for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
    localparam logic [CFG_AW-1:0] HADDR = CFG_AW'(HASH_BASE + k);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        hash_o[k] <= '0;
      else if (we_i && addr_i == HADDR)   hash_o[k] <= wdata_i;
    end
  end

  localparam logic [CFG_AW-1:0] MADDR = CFG_AW'(MODE_ADDR);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        mode_o <= '0;
    else if (we_i && addr_i == MADDR)   mode_o <= mode_t'(wdata_i[2:0]);
  end
endmodule

// File: rtl/rxf_addr_capture.sv
module rxf_addr_capture
  import rxf_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 byte_valid_i,
  input  logic                 byte_sof_i,
  input  logic [7:0]           byte_data_i,
  output logic                 take_o,
  output logic                 first_o,
  output logic                 last_o,
  output logic [ADDR_BITS-1:0] addr_o
);
  localparam int CW = $clog2(ADDR_BYTES + 1);
  localparam logic [CW-1:0] IDLE = CW'(ADDR_BYTES);
  localparam logic [CW-1:0] LAST = CW'(ADDR_BYTES - 1);

  logic [CW-1:0]           cnt_q;
  logic [CW-1:0]           pos;
  logic [ADDR_BITS-9:0]    shift_q;

  assign pos     = byte_sof_i ? '0 : cnt_q;
  assign take_o  = byte_valid_i && (byte_sof_i || cnt_q < IDLE);
  assign first_o = take_o && byte_sof_i;
  assign last_o  = take_o && pos == LAST;
  assign addr_o  = {shift_q, byte_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= IDLE;
      shift_q <= '0;
    end else if (take_o) begin
      cnt_q   <= pos + 1'b1;
      shift_q <= addr_o[ADDR_BITS-9:0];
    end
  end
endmodule

// File: rtl/rxf_hash_crc.sv
module rxf_hash_crc
  import rxf_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        take_i,
  input  logic        first_i,
  input  logic [7:0]  data_i,
  output logic [31:0] crc_next_o
);
  logic [31:0] crc_q;

  assign crc_next_o = crc_byte(first_i ? 32'hFFFF_FFFF : crc_q, data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= 32'hFFFF_FFFF;
    else if (take_i) crc_q <= crc_next_o;
  end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int N_EXACT    = 16,
  parameter int HASH_WORDS = 32,
  localparam int IDX_W     = $clog2(HASH_WORDS * 16),
  localparam int WSEL_W    = $clog2(HASH_WORDS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              last_i,
  input  logic [ADDR_BITS-1:0]              addr_i,
  input  logic [31:0]                       crc_i,
  input  logic [N_EXACT-1:0][ADDR_BITS-1:0] exact_i,
  input  logic [HASH_WORDS-1:0][15:0]       hash_i,
  input  mode_t                             mode_i,
  output logic                              valid_o,
  output logic                              accept_o,
  output match_kind_e                       kind_o,
  output logic [IDX_W-1:0]                  idx_o
);
  logic [N_EXACT-1:0] hit;
  logic               exact_any;
  logic [IDX_W-1:0]   idx_d;
  logic [WSEL_W-1:0]  word_sel;
  logic [3:0]         bit_sel;
  logic               hash_bit;
  logic               is_group;
  logic               is_bcast;
  match_kind_e        kind_d;

  // an all-zero entry is empty
  for (genvar e = 0; e < N_EXACT; e++) begin : g_cmp
    assign hit[e] = (exact_i[e] == addr_i) && (|exact_i[e]);
  end

  assign exact_any = |hit;
  assign idx_d     = crc_i[31 -: IDX_W];
  assign word_sel  = idx_d[IDX_W-1:4];
  assign bit_sel   = idx_d[3:0];
  assign hash_bit  = hash_i[word_sel][bit_sel];
  assign is_group  = addr_i[ADDR_BITS-8];
  assign is_bcast  = &addr_i;

  // promiscuous > broadcast > exact > all-multicast > hash
  always_comb begin
    kind_d = KIND_REJECT;
    if (mode_i.promisc)                     kind_d = KIND_OPEN;
    else if (is_bcast)                      kind_d = mode_i.bcast_en ? KIND_BCAST : KIND_REJECT;
    else if (exact_any)                     kind_d = KIND_EXACT;
    else if (is_group && mode_i.all_multi)  kind_d = KIND_OPEN;
    else if (is_group && hash_bit)          kind_d = KIND_HASH;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      accept_o <= 1'b0;
      kind_o   <= KIND_REJECT;
      idx_o    <= '0;
    end else if (last_i) begin
      valid_o  <= 1'b1;
      accept_o <= kind_d != KIND_REJECT;
      kind_o   <= kind_d;
      idx_o    <= idx_d;
    end else begin
      valid_o  <= 1'b0;
      accept_o <= 1'b0;
      kind_o   <= KIND_REJECT;
      idx_o    <= '0;
    end
  end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int N_EXACT    = 16,
  parameter int HASH_WORDS = 32,
  parameter int CFG_AW     = 7,
  parameter int HASH_BASE  = 64,
  parameter int MODE_ADDR  = 96,
  localparam int IDX_W     = $clog2(HASH_WORDS * 16)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [15:0]       cfg_wdata_i,
  input  logic              byte_valid_i,
  input  logic              byte_sof_i,
  input  logic [7:0]        byte_data_i,
  output logic              dec_valid_o,
  output logic              dec_accept_o,
  output logic [2:0]        dec_kind_o,
  output logic [IDX_W-1:0]  hash_idx_o
);
  logic [N_EXACT-1:0][ADDR_BITS-1:0] exact_w;
  logic [HASH_WORDS-1:0][15:0]       hash_w;
  mode_t                             mode_w;
  logic                              take_w, first_w, last_w;
  logic [ADDR_BITS-1:0]              addr_w;
  logic [31:0]                       crc_w;
  match_kind_e                       kind_w;

  rxf_cfg_regs #(
    .N_EXACT(N_EXACT), .HASH_WORDS(HASH_WORDS), .CFG_AW(CFG_AW),
    .HASH_BASE(HASH_BASE), .MODE_ADDR(MODE_ADDR)
  ) i_cfg (
    .clk_i, .rst_ni, .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .exact_o(exact_w), .hash_o(hash_w), .mode_o(mode_w)
  );

  rxf_addr_capture i_cap (
    .clk_i, .rst_ni, .byte_valid_i, .byte_sof_i, .byte_data_i,
    .take_o(take_w), .first_o(first_w), .last_o(last_w), .addr_o(addr_w)
  );

  rxf_hash_crc i_crc (
    .clk_i, .rst_ni, .take_i(take_w), .first_i(first_w), .data_i(byte_data_i),
    .crc_next_o(crc_w)
  );

  rxf_decide #(.N_EXACT(N_EXACT), .HASH_WORDS(HASH_WORDS)) i_dec (
    .clk_i, .rst_ni, .last_i(last_w), .addr_i(addr_w), .crc_i(crc_w),
    .exact_i(exact_w), .hash_i(hash_w), .mode_i(mode_w),
    .valid_o(dec_valid_o), .accept_o(dec_accept_o), .kind_o(kind_w), .idx_o(hash_idx_o)
  );

  assign dec_kind_o = kind_w;
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
  parameter int IDX_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             byte_valid_i,
  input logic             dec_valid_o,
  input logic             dec_accept_o,
  input logic [2:0]       dec_kind_o,
  input logic [IDX_W-1:0] hash_idx_o,
  input logic [2:0]       mode_i
);
  p_one_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |=> !dec_valid_o);

  p_after_byte_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> $past(byte_valid_i));

  p_accept_code_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o |-> (dec_accept_o == (dec_kind_o != 3'd0)) && dec_kind_o <= 3'd4);

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_o |-> !dec_accept_o && dec_kind_o == 3'd0 && hash_idx_o == '0);

  p_promisc_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && $past(mode_i[0]) |-> dec_accept_o && dec_kind_o == 3'd4);

  p_bcast_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_o && !$past(mode_i[2]) |-> dec_kind_o != 3'd3);
endmodule

bind rx_addr_filter rxf_filter_chk #(.IDX_W(IDX_W)) i_rxf_filter_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_i(byte_valid_i),
  .dec_valid_o(dec_valid_o), .dec_accept_o(dec_accept_o), .dec_kind_o(dec_kind_o),
  .hash_idx_o(hash_idx_o), .mode_i(mode_w)
);

// File: tb/test_rx_addr_filter.sv
`timescale 1ns/1ps
module test_rx_addr_filter;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [6:0]  cfg_addr_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic        byte_valid_i = 1'b0;
  logic        byte_sof_i = 1'b0;
  logic [7:0]  byte_data_i = '0;
  logic        dec_valid_o, dec_accept_o;
  logic [2:0]  dec_kind_o;
  logic [8:0]  hash_idx_o;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  logic [47:0] sh_exact [16];
  logic [15:0] sh_hash  [32];
  logic [2:0]  sh_mode;

  always #2.5 clk_i = ~clk_i;

  rx_addr_filter i_rx_addr_filter (.*);

  function automatic logic [8:0] model_idx(logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int b = 0; b < 6; b++) begin
      logic [7:0] d = a[47-8*b -: 8];
      for (int i = 0; i < 8; i++) begin
        logic f = c[31] ^ d[i];
        c = c << 1;
        if (f) c = c ^ 32'h04C1_1DB7;
      end
    end
    return c[31:23];
  endfunction

  function automatic logic [2:0] model_kind(logic [47:0] a);
    logic [8:0] ix = model_idx(a);
    bit hit = 0;
    for (int e = 0; e < 16; e++) if (sh_exact[e] == a && a != 48'd0) hit = 1;
    if (sh_mode[0]) return 3'd4;
    if (&a) return sh_mode[2] ? 3'd3 : 3'd0;
    if (hit) return 3'd1;
    if (a[40] && sh_mode[1]) return 3'd4;
    if (a[40] && sh_hash[ix[8:4]][ix[3:0]]) return 3'd2;
    return 3'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_wr(input logic [6:0] a, input logic [15:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
    if (a < 7'd48) sh_exact[a/3][16*(a%3) +: 16] = d;
    else if (a >= 7'd64 && a < 7'd96) sh_hash[a-64] = d;
    else if (a == 7'd96) sh_mode = d[2:0];
  endtask

  // R4: last halfword (word 0) first
  task automatic set_entry(input int e, input logic [47:0] a);
    for (int w = 0; w < 3; w++) cfg_wr(7'(3*e + w), a[16*w +: 16]);
  endtask

  // drive six bytes; on return the decision cycle is current
  task automatic send(input logic [47:0] a, input bit gap);
    for (int i = 0; i < 6; i++) begin
      byte_valid_i = 1'b1; byte_sof_i = (i == 0); byte_data_i = a[47-8*i -: 8];
      @(negedge clk_i);
      if (gap && i == 2) begin
        byte_valid_i = 1'b0; byte_sof_i = 1'b0;
        @(negedge clk_i);
      end
    end
    byte_valid_i = 1'b0; byte_sof_i = 1'b0;
  endtask

  task automatic check_dec(input logic [47:0] a, input string req);
    logic [2:0] ek = model_kind(a);
    logic [8:0] ei = model_idx(a);
    chk(dec_valid_o === 1'b1, "R2", "valid", 16'(dec_valid_o), 16'd1);
    chk(dec_kind_o === ek, req, "kind", 16'(dec_kind_o), 16'(ek));
    chk(dec_accept_o === (ek != 0), "R11", "accept", 16'(dec_accept_o), 16'(ek != 0));
    chk(hash_idx_o === ei, "R3", "hash index", 16'(hash_idx_o), 16'(ei));
  endtask

  function automatic string req_of(logic [2:0] k);
    case (k)
      3'd1: return "R4";
      3'd2: return "R6";
      3'd3: return "R7";
      3'd4: return "R8";
      default: return "R10";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!ended) begin
      ended = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [47:0] a, b, st;
    void'($urandom(32'd1234));
    for (int e = 0; e < 16; e++) sh_exact[e] = '0;
    for (int k = 0; k < 32; k++) sh_hash[k] = '0;
    sh_mode = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(dec_valid_o === 1'b0, "R1", "valid after reset", 16'(dec_valid_o), 16'd0);
    send(48'hFFFF_FFFF_FFFF, 0);
    chk(dec_kind_o === 3'd0 && dec_valid_o, "R1", "bcast at reset", 16'(dec_kind_o), 16'd0);
    // R5 all-zero entries empty
    send(48'h0, 0);
    check_dec(48'h0, "R5");

    // R4 station entry
    st = 48'h0200_1122_3344;
    set_entry(0, st);
    send(st, 0);
    check_dec(st, "R4");
    chk(dec_kind_o === 3'd1, "R4", "station kind", 16'(dec_kind_o), 16'd1);
    // R2 single pulse and trailing bytes ignored
    byte_valid_i = 1'b1; byte_data_i = 8'h55;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
    chk(dec_valid_o === 1'b0, "R2", "pulse width", 16'(dec_valid_o), 16'd0);
    @(negedge clk_i);
    chk(dec_valid_o === 1'b0, "R2", "extra byte ignored", 16'(dec_valid_o), 16'd0);
    // R2 gap and restart on sof
    send(st, 1);
    check_dec(st, "R2");
    b = 48'h0200_1122_3345;
    for (int i = 0; i < 3; i++) begin
      byte_valid_i = 1'b1; byte_sof_i = (i == 0); byte_data_i = b[47-8*i -: 8];
      @(negedge clk_i);
    end
    send(st, 0);
    check_dec(st, "R2");

    // R10 unicast with hash bit set is rejected
    a = 48'h0A00_0000_0077;
    cfg_wr(7'(64 + model_idx(a) / 16), 16'(1 << (model_idx(a) % 16)));
    send(a, 0);
    check_dec(a, "R10");
    chk(dec_kind_o === 3'd0, "R10", "unicast hash", 16'(dec_kind_o), 16'd0);
    // R6 group address hash hit
    a = 48'h0100_5E00_0001;
    cfg_wr(7'(64 + model_idx(a) / 16), 16'(1 << (model_idx(a) % 16)));
    send(a, 0);
    check_dec(a, "R6");
    chk(dec_kind_o === 3'd2, "R6", "group hash", 16'(dec_kind_o), 16'd2);
    // R8 all-multicast with exact precedence
    set_entry(5, 48'h0100_5E7F_0002);
    cfg_wr(7'd96, 16'h0002);
    send(48'h0300_0000_0009, 0);
    check_dec(48'h0300_0000_0009, "R8");
    send(48'h0100_5E7F_0002, 0);
    check_dec(48'h0100_5E7F_0002, "R8");
    // R7 broadcast gate
    send(48'hFFFF_FFFF_FFFF, 0);
    check_dec(48'hFFFF_FFFF_FFFF, "R7");
    cfg_wr(7'd96, 16'h0004);
    send(48'hFFFF_FFFF_FFFF, 0);
    check_dec(48'hFFFF_FFFF_FFFF, "R7");
    // R9 promiscuous
    cfg_wr(7'd96, 16'h0001);
    send(48'h0A0B_0C0D_0E0F, 0);
    check_dec(48'h0A0B_0C0D_0E0F, "R9");
    send(48'h0, 0);
    check_dec(48'h0, "R9");

    // random phase
    for (int n = 0; n < 600; n++) begin
      if (n % 60 == 0) begin
        for (int e = 1; e < 16; e++)
          if ($urandom % 2) set_entry(e, {$urandom, 16'($urandom)});
        for (int k = 0; k < 32; k++) cfg_wr(7'(64 + k), 16'($urandom));
        cfg_wr(7'd96, ($urandom % 8 == 0) ? 16'h1 : 16'($urandom & 32'h6));
      end
      case ($urandom % 8)
        0, 1:    a = sh_exact[$urandom % 16];
        2:       a = 48'hFFFF_FFFF_FFFF;
        default: a = {$urandom, 16'($urandom)};
      endcase
      send(a, ($urandom % 4) == 0);
      check_dec(a, req_of(model_kind(a)));
    end

    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule